// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block is a clocked front end for a 256K x 16 asynchronous static RAM that has separate enables for its upper and lower byte. A host issues one request at a time over a valid/ready handshake. Each request carries an 18-bit word address, a write flag, 16-bit write data, a 2-bit byte mask and a burst flag. The controller turns each request into a sequence of active-low chip, output, write and per-byte enables. Read data comes back registered, marked by a one-cycle valid pulse.

Every timing interval is a whole number of clock cycles, set by a parameter: the read window, the write pulse and the read-to-write turnaround. A chain of writes that carry the burst flag keeps the write and chip enables low from one word to the next. In that case only the byte enables frame each word, and the data bus stays driven. Between accesses the chip enable is high, so the memory rests in standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip, output, write and both byte enables are high, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read accepted at a clock edge holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for the next RD_CYC cycles, with the request address on `mem_addr`. Byte enable i is low exactly when mask bit i is 1 (bit 0 is data bits 7:0, bit 1 is bits 15:8).
- R3: `mem_dq_in` is sampled at the edge that ends the read window. In the cycle that follows, `rsp_valid` is 1 for exactly one cycle and `rsp_rdata` holds the sampled data, with the lanes outside the mask forced to zero.
- R4: A write starts at the edge after acceptance, or at the edge that ends a turnaround. It holds `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1 for WR_CYC cycles, with the write data on `mem_dq_out`. The byte enables follow the mask as in R2.
- R5: A write without the burst flag ends at one edge: all strobes return high and `mem_dq_oe` drops to 0 in that same edge.
- R6: A write whose mask is 00 lowers no byte enable, so the memory contents are unchanged.
- R7: `req_ready` is 1 only when no access is in flight (idle or burst gap). Whenever `req_ready` is 1 and `mem_we_n` is 1, `mem_ce_n` is 1.
- R8: A write accepted while the previous access was a read waits TA_CYC cycles with all strobes high before `mem_we_n` falls. In every case `mem_oe_n` is high in the cycle before `mem_we_n` falls.
- R9: `mem_we_n` is never low while `mem_oe_n` is low, and `mem_dq_oe` is never 1 while `mem_oe_n` is low.
- R10: When a burst write's pulse ends, the byte enables rise while `mem_ce_n`, `mem_we_n` and `mem_dq_oe` stay unchanged. `req_ready` is then 1 for one gap cycle. A write accepted in that cycle lowers its byte enables at the next edge, and `mem_we_n` does not rise in between.
- R11: If no request arrives in a burst gap, all strobes rise and the bus is released at the next edge. A read accepted in the gap closes the burst the same way and then waits TA_CYC cycles before its read window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Keep write enable low after this write for a following write |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte mask, bit 0 lower byte, bit 1 upper byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Byte enables, bit 0 lower byte, bit 1 upper byte, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_in | input | 16 | Data received from memory |
| mem_dq_oe | output | 1 | Data bus driver enable |

## Verification
The assertions assume that the host holds a request stable from the cycle it raises `req_valid` until `req_ready` takes it. They also assume that `mem_dq_in` is settled by the clock edge that closes a read window, and that TA_CYC is at least 1. The bench changes host inputs only on the falling clock edge and waits for `req_ready` before it lets a request go. It offers each burst continuation in the gap cycle. Its memory model drives fresh data half a cycle after the strobes change and drives filler bytes on lanes that are not enabled, so any lane that is not masked off would show up.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 1,
  parameter int TA_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W/8-1:0] mem_lane_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int LANES = DATA_W / 8;
  localparam int CMAX  = (RD_CYC > WR_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                           : ((WR_CYC > TA_CYC) ? WR_CYC : TA_CYC);
  localparam int CW    = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_READ, S_WRITE, S_GAP} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic              last_rd;
  logic              p_wr, p_burst, cur_burst;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_data;
  logic [LANES-1:0]  p_be, cur_be;
  logic              take, launch, use_req;
  logic              n_wr, n_burst;
  logic [ADDR_W-1:0] n_addr;
  logic [DATA_W-1:0] n_data;
  logic [LANES-1:0]  n_be;
  logic [DATA_W-1:0] rd_keep;

  assign req_ready = (st == S_IDLE) || (st == S_GAP);
  assign take      = req_valid && req_ready;

  always_comb begin
    launch  = 1'b0;
    use_req = 1'b1;
    case (st)
      S_IDLE:  launch = take && !(req_write && last_rd);
      S_TURN:  begin launch = (cnt == '0); use_req = 1'b0; end
      S_GAP:   launch = take && req_write;
      default: launch = 1'b0;
    endcase
  end

  assign n_wr    = use_req ? req_write : p_wr;
  assign n_burst = use_req ? req_burst : p_burst;
  assign n_addr  = use_req ? req_addr  : p_addr;
  assign n_data  = use_req ? req_wdata : p_data;
  assign n_be    = use_req ? req_be    : p_be;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_keep[g*8 +: 8] = cur_be[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      last_rd    <= 1'b0;
      p_wr       <= 1'b0;
      p_burst    <= 1'b0;
      p_addr     <= '0;
      p_data     <= '0;
      p_be       <= '0;
      cur_be     <= '0;
      cur_burst  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_lane_n <= '1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (take) begin
        p_wr    <= req_write;
        p_burst <= req_burst;
        p_addr  <= req_addr;
        p_data  <= req_wdata;
        p_be    <= req_be;
      end
      if (launch) begin
        mem_addr   <= n_addr;
        mem_ce_n   <= 1'b0;
        mem_lane_n <= ~n_be;
        cur_be     <= n_be;
        cur_burst  <= n_burst;
        if (n_wr) begin
          mem_we_n   <= 1'b0;
          mem_oe_n   <= 1'b1;
          mem_dq_out <= n_data;
          mem_dq_oe  <= 1'b1;
          cnt        <= CW'(WR_CYC - 1);
          last_rd    <= 1'b0;
          st         <= S_WRITE;
        end else begin
          mem_we_n   <= 1'b1;
          mem_oe_n   <= 1'b0;
          mem_dq_oe  <= 1'b0;
          cnt        <= CW'(RD_CYC - 1);
          last_rd    <= 1'b1;
          st         <= S_READ;
        end
      end else begin
        case (st)
          S_IDLE: if (take) begin
            cnt <= CW'(TA_CYC - 1);
            st  <= S_TURN;
          end
          S_TURN: cnt <= cnt - 1'b1;
          S_READ: if (cnt == '0) begin
            rsp_rdata  <= rd_keep;
            rsp_valid  <= 1'b1;
            mem_ce_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_lane_n <= '1;
            st         <= S_IDLE;
          end else cnt <= cnt - 1'b1;
          S_WRITE: if (cnt == '0) begin
            mem_lane_n <= '1;
            if (cur_burst) st <= S_GAP;
            else begin
              mem_ce_n  <= 1'b1;
              mem_we_n  <= 1'b1;
              mem_dq_oe <= 1'b0;
              st        <= S_IDLE;
            end
          end else cnt <= cnt - 1'b1;
          S_GAP: begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            if (take) begin
              cnt <= CW'(TA_CYC - 1);
              st  <= S_TURN;
            end else st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module sram_lane_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       mem_ce_n,
  input logic       mem_oe_n,
  input logic       mem_we_n,
  input logic       mem_dq_oe
);
  assert_no_write_while_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  assert_drive_only_oe_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_write_needs_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  assert_read_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));
  assert_busy_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !req_ready);
  assert_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && mem_we_n) |-> mem_ce_n);
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_oe_high_before_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_oe_n));
  assert_release_with_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;
  localparam int RD = 3, WR = 2, TA = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out;
  logic [15:0] mem_dq_in = '0;
  logic [17:0] mem_addr;
  logic [1:0]  mem_lane_n;

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.RD_CYC(RD), .WR_CYC(WR), .TA_CYC(TA)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // host-view memory and pin-level memory
  logic [15:0] smem [int];
  logic [7:0]  pm_lo [int];
  logic [7:0]  pm_hi [int];

  // reference model state
  int ph = 0, pph = 0, left = 0;
  bit mlast = 0, mbu = 0, tk;
  logic [17:0] ma = '0;
  logic [1:0]  mbe = '0;
  bit pw = 0, pbu = 0;
  logic [17:0] pa = '0;
  logic [15:0] pd = '0;
  logic [1:0]  pbe = '0;
  logic e_ce = 1, e_oe = 1, e_we = 1, e_dqoe = 0, e_rdy = 1, e_rv = 0;
  logic [1:0]  e_lane = 2'b11;
  logic [17:0] e_addr = '0;
  logic [15:0] e_dout = '0, e_rdata = '0;

  function automatic logic [15:0] smem_get(input logic [17:0] a);
    return smem.exists(int'(a)) ? smem[int'(a)] : 16'h0000;
  endfunction

  task automatic idle_pins();
    e_ce = 1; e_oe = 1; e_we = 1; e_lane = 2'b11; e_dqoe = 0;
  endtask

  task automatic hold_req();
    pw = req_write; pa = req_addr; pd = req_wdata; pbe = req_be; pbu = req_burst;
  endtask

  task automatic begin_acc(input bit w, input logic [17:0] a, input logic [15:0] d,
                           input logic [1:0] be, input bit bu);
    logic [15:0] old;
    e_ce = 0; e_addr = a; e_lane = ~be; ma = a; mbe = be; mbu = bu;
    if (w) begin
      e_we = 0; e_oe = 1; e_dqoe = 1; e_dout = d; ph = 3; left = WR; mlast = 0;
      old = smem_get(a);
      if (be[0]) old[7:0] = d[7:0];
      if (be[1]) old[15:8] = d[15:8];
      smem[int'(a)] = old;
    end else begin
      e_we = 1; e_oe = 0; e_dqoe = 0; ph = 2; left = RD; mlast = 1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; left = 0; mlast = 0; e_rv = 0; e_rdy = 1; idle_pins();
    end else begin
      pph = ph; e_rv = 0;
      tk = req_valid && (ph == 0 || ph == 4);
      case (ph)
        0: if (tk) begin
             if (req_write && mlast) begin hold_req(); ph = 1; left = TA; end
             else begin_acc(req_write, req_addr, req_wdata, req_be, req_burst);
           end
        1: begin left--; if (left == 0) begin_acc(pw, pa, pd, pbe, pbu); end
        2: begin
             left--;
             if (left == 0) begin
               e_rdata = smem_get(ma);
               if (!mbe[0]) e_rdata[7:0] = 8'h00;
               if (!mbe[1]) e_rdata[15:8] = 8'h00;
               e_rv = 1; idle_pins(); ph = 0;
             end
           end
        3: begin
             left--;
             if (left == 0) begin
               if (mbu) begin e_lane = 2'b11; ph = 4; end
               else begin idle_pins(); ph = 0; end
             end
           end
        default: begin
             if (tk && req_write) begin_acc(1'b1, req_addr, req_wdata, req_be, req_burst);
             else if (tk) begin hold_req(); idle_pins(); ph = 1; left = TA; end
             else begin idle_pins(); ph = 0; end
           end
      endcase
      e_rdy = (ph == 0 || ph == 4);
    end
  end

  logic [15:0] got = '0;
  int got_n = 0;

  always @(negedge clk) begin
    string tag;
    if (rst_n) begin
      if (pph == 3 && ph == 4) tag = "R10";
      else if (pph == 3 && ph != 3) tag = "R5";
      else if (ph == 4) tag = "R10";
      else if (pph == 4 && ph != 3) tag = "R11";
      else if (ph == 2) tag = "R2";
      else if (ph == 3) tag = "R4";
      else if (ph == 1) tag = "R8";
      else tag = "R7";
      chk(mem_ce_n === e_ce, tag, "ce_n", 32'(mem_ce_n), 32'(e_ce));
      chk(mem_oe_n === e_oe, tag, "oe_n", 32'(mem_oe_n), 32'(e_oe));
      chk(mem_we_n === e_we, tag, "we_n", 32'(mem_we_n), 32'(e_we));
      chk(mem_lane_n === e_lane, tag, "lane_n", 32'(mem_lane_n), 32'(e_lane));
      chk(mem_dq_oe === e_dqoe, tag, "dq_oe", 32'(mem_dq_oe), 32'(e_dqoe));
      chk(req_ready === e_rdy, "R7", "ready", 32'(req_ready), 32'(e_rdy));
      chk(rsp_valid === e_rv, "R3", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
      if (!e_ce) chk(mem_addr === e_addr, tag, "addr", 32'(mem_addr), 32'(e_addr));
      if (e_dqoe) chk(mem_dq_out === e_dout, tag, "dq_out", 32'(mem_dq_out), 32'(e_dout));
      if (e_rv) chk(rsp_rdata === e_rdata, "R3", "rdata", 32'(rsp_rdata), 32'(e_rdata));
      chk(!(!mem_we_n && !mem_oe_n), "R9", "we and oe both low", 32'({mem_we_n, mem_oe_n}), 32'h2);
      if (rsp_valid) begin got = rsp_rdata; got_n++; end
    end
    // pin-level memory model
    if (!mem_ce_n && !mem_we_n) begin
      if (!mem_lane_n[0]) pm_lo[int'(mem_addr)] = mem_dq_out[7:0];
      if (!mem_lane_n[1]) pm_hi[int'(mem_addr)] = mem_dq_out[15:8];
    end
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      mem_dq_in[7:0]  = mem_lane_n[0] ? 8'hA5 :
                        (pm_lo.exists(int'(mem_addr)) ? pm_lo[int'(mem_addr)] : 8'h00);
      mem_dq_in[15:8] = mem_lane_n[1] ? 8'h5A :
                        (pm_hi.exists(int'(mem_addr)) ? pm_hi[int'(mem_addr)] : 8'h00);
    end else mem_dq_in = 16'hA55A;
  end

  task automatic send(input bit w, input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] be, input bit bu);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be; req_burst = bu;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_burst = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_chk(input logic [17:0] a, input logic [1:0] be,
                          input logic [15:0] exp, input string tag);
    int n0 = got_n;
    send(1'b0, a, 16'h0, be, 1'b0);
    while (got_n == n0) @(negedge clk);
    chk(got === exp, tag, "readback", 32'(got), 32'(exp));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mem_ce_n, mem_oe_n, mem_we_n, mem_lane_n} === 5'b11111, "R1", "strobes",
        32'({mem_ce_n, mem_oe_n, mem_we_n, mem_lane_n}), 32'h1f);
    chk(mem_dq_oe === 1'b0, "R1", "dq_oe", 32'(mem_dq_oe), 0);
    chk(req_ready === 1'b1, "R1", "ready", 32'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 0);
    rst_n = 1;
    idle(2);
    // R4 basic write and R3 readback
    send(1'b1, 18'h0, 16'h1234, 2'b11, 1'b0);
    read_chk(18'h0, 2'b11, 16'h1234, "R3");
    // lane gating
    send(1'b1, 18'h1, 16'hAAAA, 2'b11, 1'b0);
    send(1'b1, 18'h1, 16'h5555, 2'b01, 1'b0);
    read_chk(18'h1, 2'b10, 16'hAA00, "R3");
    read_chk(18'h1, 2'b11, 16'hAA55, "R4");
    read_chk(18'h1, 2'b01, 16'h0055, "R2");
    // R6 empty mask write
    send(1'b1, 18'h0, 16'hFFFF, 2'b00, 1'b0);
    read_chk(18'h0, 2'b11, 16'h1234, "R6");
    // R8 read followed at once by a write
    send(1'b0, 18'h0, 16'h0, 2'b11, 1'b0);
    send(1'b1, 18'h2, 16'h0F0F, 2'b11, 1'b0);
    read_chk(18'h2, 2'b11, 16'h0F0F, "R8");
    // top address
    send(1'b1, 18'h3FFFF, 16'hC3C3, 2'b11, 1'b0);
    read_chk(18'h3FFFF, 2'b11, 16'hC3C3, "R2");
    // R10 burst chain
    send(1'b1, 18'h10, 16'h1111, 2'b11, 1'b1);
    send(1'b1, 18'h11, 16'h2222, 2'b01, 1'b1);
    send(1'b1, 18'h12, 16'h3333, 2'b10, 1'b1);
    send(1'b1, 18'h13, 16'h4444, 2'b11, 1'b0);
    read_chk(18'h10, 2'b11, 16'h1111, "R10");
    read_chk(18'h11, 2'b11, 16'h0022, "R10");
    read_chk(18'h12, 2'b11, 16'h3300, "R10");
    read_chk(18'h13, 2'b11, 16'h4444, "R10");
    // R11 burst closed by silence, then by a read
    send(1'b1, 18'h20, 16'hABCD, 2'b11, 1'b1);
    idle(4);
    send(1'b1, 18'h21, 16'h1357, 2'b11, 1'b1);
    read_chk(18'h20, 2'b11, 16'hABCD, "R11");
    read_chk(18'h21, 2'b11, 16'h1357, "R11");
    // burst after a read: turnaround then chained words
    send(1'b0, 18'h21, 16'h0, 2'b11, 1'b0);
    send(1'b1, 18'h30, 16'h9876, 2'b11, 1'b1);
    send(1'b1, 18'h31, 16'h0000, 2'b00, 1'b0);
    read_chk(18'h30, 2'b11, 16'h9876, "R8");
    read_chk(18'h31, 2'b11, 16'h0000, "R6");
    idle(4);
    finish_run();
  end
endmodule